// File: doc/BRIEF.md
# Shared Memory Access Sequencer

This block lets one single-port synchronous RAM serve both a CPU and a video scanner. A free-running two-bit sequence counter splits every four master-clock cycles into two halves. In the first half the CPU owns the RAM, and in the second half the video scanner owns it. The upper bit of the counter is exported as the CPU clock, so the CPU and the scanner never compete for the RAM and no arbitration is needed.

The block also decodes a minimal home-computer memory map. A lower ROM sits at 0x0000–0x3FFF and an upper ROM at 0xC000–0xFFFF. Memory reads in those windows return ROM data, and memory reads in 0x4000–0xBFFF return RAM contents. Memory writes always land in RAM, including writes beneath either ROM. I/O writes do nothing and I/O reads return zero. The scanner gives a 14-bit offset into the top 16 KB of RAM and receives one byte per sequence period. The ROM sits outside the block and is read combinationally.

Top module: `mem_phase_arbiter`

## Requirements
- R1: The sequence counter counts phases 0,1,2,3 and then wraps to 0, advancing on every rising master-clock edge. Reset puts it in phase 0. `cpu_clk` is low in phases 0 and 1 and high in phases 2 and 3. After reset, `cpu_rdata` and `vid_rdata` are 0.
- R2: `ram_we` is high only in phase 0, and only while `cpu_mreq`=1 and `cpu_wr`=1. During that phase `ram_addr` equals `cpu_addr` and `ram_wdata` equals `cpu_wdata`.
- R3: In phases 0 and 1 `ram_addr` equals `cpu_addr`. In phases 2 and 3 it equals {2'b11, `vid_addr`}, which lies in 0xC000–0xFFFF.
- R4: `rom_addr` is `cpu_addr[13:0]` and `rom_upper` is `cpu_addr[15]`. A memory read (`cpu_mreq`=1, `cpu_wr`=0) with `cpu_addr[15:14]` equal to 00 or 11 loads `rom_rdata` into `cpu_rdata` at the edge that ends phase 1.
- R5: A memory read with `cpu_addr[15:14]` equal to 01 or 10 loads the RAM byte at `cpu_addr` into `cpu_rdata` at the edge that ends phase 1.
- R6: Memory writes reach RAM at any address, including beneath both ROM windows. A write beneath the upper ROM becomes visible on the video port.
- R7: An I/O write (`cpu_mreq`=0, `cpu_iorq`=1, `cpu_wr`=1) never asserts `ram_we` and leaves `cpu_rdata` unchanged.
- R8: An I/O read (`cpu_mreq`=0, `cpu_iorq`=1, `cpu_wr`=0) sets `cpu_rdata` to 0x00 at the edge that ends phase 1.
- R9: At the edge that ends phase 3, `vid_rdata` takes the RAM byte at 0xC000 + `vid_addr` as it was read in phases 2 and 3. It then holds for the next four cycles.
- R10: `cpu_rdata` changes only at the edge that ends phase 1. With no read request it holds its value. When `cpu_mreq` and `cpu_iorq` are both high, the request is treated as a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| cpu_clk | output | 1 | CPU clock, upper bit of the sequence counter |
| cpu_mreq | input | 1 | CPU memory request |
| cpu_iorq | input | 1 | CPU I/O request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data returned to the CPU |
| vid_addr | input | 14 | Scanner offset into the top 16 KB |
| vid_rdata | output | 8 | Data returned to the scanner |
| rom_addr | output | 14 | ROM byte offset |
| rom_upper | output | 1 | 1 selects the upper ROM image |
| rom_rdata | input | 8 | Combinational ROM data |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, one cycle after address |

## Verification
The hardest case to show is that a CPU write lands in RAM beneath a ROM window. A CPU read of the same address returns ROM data, so the CPU can never see the stored byte. For the upper window, the stimulus writes a byte under 0xC000 and then points the scanner offset at it, so the byte appears on `vid_rdata`. The bench then reads the same address from the CPU side and expects the ROM value. The bench changes CPU inputs just before phase 0 and the scanner offset just before phase 2. Each capture therefore tests one known request.

// File: rtl/mem_phase_arbiter.sv
module mem_phase_arbiter #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cpu_clk,
  input  logic          cpu_mreq,
  input  logic          cpu_iorq,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-3:0] vid_addr,
  output logic [DW-1:0] vid_rdata,
  output logic [AW-3:0] rom_addr,
  output logic          rom_upper,
  input  logic [DW-1:0] rom_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  input  logic [DW-1:0] ram_rdata
);
  localparam int WAW = AW - 2;
  localparam logic [1:0] PH_CPU_WR  = 2'd0;
  localparam logic [1:0] PH_CPU_END = 2'd1;
  localparam logic [1:0] PH_VID_END = 2'd3;

  logic [1:0] seq;

  wire [1:0] region = cpu_addr[AW-1:WAW];
  wire in_rom = (region == 2'b00) || (region == 2'b11);
  wire mem_rd = cpu_mreq & ~cpu_wr;
  wire mem_wr = cpu_mreq & cpu_wr;
  wire io_rd  = ~cpu_mreq & cpu_iorq & ~cpu_wr;

  always_ff @(posedge clk or posedge rst)
    if (rst) seq <= 2'd0;
    else     seq <= seq + 2'd1;

  assign cpu_clk   = seq[1];
  assign ram_addr  = seq[1] ? {2'b11, vid_addr} : cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = (seq == PH_CPU_WR) && mem_wr;
  assign rom_addr  = cpu_addr[WAW-1:0];
  assign rom_upper = cpu_addr[AW-1];

  always_ff @(posedge clk or posedge rst)
    if (rst) cpu_rdata <= '0;
    else if (seq == PH_CPU_END) begin
      if (mem_rd)     cpu_rdata <= in_rom ? rom_rdata : ram_rdata;
      else if (io_rd) cpu_rdata <= '0;
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) vid_rdata <= '0;
    else if (seq == PH_VID_END) vid_rdata <= ram_rdata;
endmodule

// File: rtl/mem_phase_arbiter_chk.sv
module mem_phase_arbiter_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    seq,
  input logic          cpu_mreq,
  input logic          cpu_iorq,
  input logic          cpu_wr,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] cpu_rdata,
  input logic [DW-1:0] vid_rdata
);
  assert_we_phase0_R2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (seq == 2'd0 && cpu_mreq && cpu_wr));

  assert_io_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!cpu_mreq && cpu_iorq) |-> !ram_we);

  assert_vid_window_R3: assert property (@(posedge clk) disable iff (rst)
    seq[1] |-> (ram_addr[AW-1:AW-2] == 2'b11));

  assert_vid_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (seq != 2'd3) |=> $stable(vid_rdata));

  assert_cpu_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (seq != 2'd1) |=> $stable(cpu_rdata));
endmodule

bind mem_phase_arbiter mem_phase_arbiter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .seq(seq), .cpu_mreq(cpu_mreq), .cpu_iorq(cpu_iorq),
  .cpu_wr(cpu_wr), .ram_we(ram_we), .ram_addr(ram_addr),
  .cpu_rdata(cpu_rdata), .vid_rdata(vid_rdata)
);

// File: tb/test_mem_phase_arbiter.sv
module test_mem_phase_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 0, rst = 1;
  logic cpu_mreq = 0, cpu_iorq = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [13:0] vid_addr = 0;
  logic cpu_clk, rom_upper, ram_we;
  logic [7:0] cpu_rdata, vid_rdata, rom_rdata, ram_wdata;
  logic [7:0] ram_rdata = 0;
  logic [13:0] rom_addr;
  logic [15:0] ram_addr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_phase_arbiter i_mem_phase_arbiter (
    .clk(clk), .rst(rst), .cpu_clk(cpu_clk), .cpu_mreq(cpu_mreq),
    .cpu_iorq(cpu_iorq), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_addr(vid_addr),
    .vid_rdata(vid_rdata), .rom_addr(rom_addr), .rom_upper(rom_upper),
    .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_f(logic up, logic [13:0] a);
    return a[7:0] ^ a[13:6] ^ (up ? 8'hA5 : 8'h3C);
  endfunction

  assign rom_rdata = rom_f(rom_upper, rom_addr);

  // Environment RAM, driven by the design's pins
  logic [7:0] env_mem [int];
  always @(posedge clk) begin
    ram_rdata <= env_mem.exists(int'(ram_addr)) ? env_mem[int'(ram_addr)] : 8'h00;
    if (ram_we) env_mem[int'(ram_addr)] = ram_wdata;
  end

  // Reference model
  logic [7:0] ref_mem [int];
  int ph = 0;
  logic [7:0] exp_cpu = 0, exp_vid = 0;

  function automatic logic [7:0] rd_ref(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; exp_cpu = 0; exp_vid = 0;
    end else begin
      case (ph)
        0: if (cpu_mreq && cpu_wr) ref_mem[int'(cpu_addr)] = cpu_wdata;
        1: if (cpu_mreq && !cpu_wr)
             exp_cpu = (cpu_addr[15:14] == 2'b00 || cpu_addr[15:14] == 2'b11)
                       ? rom_f(cpu_addr[15], cpu_addr[13:0]) : rd_ref(int'(cpu_addr));
           else if (cpu_iorq && !cpu_wr) exp_cpu = 8'h00;
        3: exp_vid = rd_ref(int'({2'b11, vid_addr}));
        default: ;
      endcase
      ph = (ph + 1) % 4;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 cpu_clk", 16'(cpu_clk), 16'(ph >= 2));
      chk("R2/R7 ram_we", 16'(ram_we), 16'(ph == 0 && cpu_mreq && cpu_wr));
      if (ram_we) chk("R2 ram_wdata", 16'(ram_wdata), 16'(cpu_wdata));
      chk("R3 ram_addr", ram_addr, (ph < 2) ? cpu_addr : {2'b11, vid_addr});
      chk("R4 rom_addr", {1'b0, rom_upper, rom_addr}, {1'b0, cpu_addr[15], cpu_addr[13:0]});
      chk("R4/R5/R8/R10 cpu_rdata", 16'(cpu_rdata), 16'(exp_cpu));
      chk("R6/R9 vid_rdata", 16'(vid_rdata), 16'(exp_vid));
    end
  end

  // CPU inputs change just before phase 0, scanner offset just before phase 2
  task automatic cpu_req(logic m, logic io, logic w, logic [15:0] a, logic [7:0] d);
    do @(negedge clk); while (ph != 3);
    #1;
    cpu_mreq = m; cpu_iorq = io; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic vid_set(logic [13:0] va);
    do @(negedge clk); while (ph != 1);
    #1;
    vid_addr = va;
  endtask

  task automatic idle();
    cpu_req(0, 0, 0, cpu_addr, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset cpu_rdata", 16'(cpu_rdata), 16'h0);
    chk("R1 reset vid_rdata", 16'(vid_rdata), 16'h0);
    #1 rst = 0;

    // R6: write beneath upper ROM, seen through the scanner
    cpu_req(1, 0, 1, 16'hC010, 8'h5A);
    vid_set(14'h0010);
    idle();
    // R4: CPU read at same address returns upper ROM image
    cpu_req(1, 0, 0, 16'hC010, 8'h00);
    // R6: write beneath lower ROM, read returns lower ROM
    cpu_req(1, 0, 1, 16'h0005, 8'h77);
    cpu_req(1, 0, 0, 16'h0005, 8'h00);
    // R5: middle region RAM
    cpu_req(1, 0, 1, 16'h4123, 8'h9C);
    cpu_req(1, 0, 1, 16'hBFFF, 8'hE1);
    cpu_req(1, 0, 0, 16'h4123, 8'h00);
    cpu_req(1, 0, 0, 16'hBFFF, 8'h00);
    // R7: I/O write has no effect, R10 hold after it
    cpu_req(0, 1, 1, 16'hC020, 8'h33);
    vid_set(14'h0020);
    idle();
    idle();
    // R8: I/O read returns zero
    cpu_req(0, 1, 0, 16'h4123, 8'hFF);
    // R10: memory wins over I/O when both are set
    cpu_req(1, 1, 0, 16'h4123, 8'h00);
    idle();
    // Mixed walk over all regions
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a;
      a = 16'((i * 16'h2A71) ^ (i << 13));
      cpu_req(1, 0, 1, a, 8'(i * 37 + 11));
      vid_set(a[13:0]);
      cpu_req(1, 0, 0, a, 8'h00);
      cpu_req(0, 1, i[0], a, 8'h00);
    end
    idle();
    repeat (8) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule